// File: doc/BRIEF.md
# Interrupt Source Bank with Level and Message Sources

This block holds a bank of interrupt sources and turns their activity into presentation requests for the presenters that serve the processors. Each source is built as either level-sensitive or message type, set per source by a parameter bitmap. Each source stores its own target server and priority. Software-side configuration arrives on a write port. Trigger activity arrives on one input line per source. Presenters answer with reject, end-of-interrupt (EOI) and resend strobes. Each request carries the target server, the global source number and the priority. The global number is the local index plus a base offset.

The two source kinds answer the return strobes differently. A message source remembers a reject and a masked trigger, and replays each later. A level source follows its input line and tracks whether it has been sent. A level source is re-offered only when a check event finds it asserted, unmasked and not sent. At most one request leaves the bank per cycle. The lowest-numbered waiting source goes first. A resend request walks the sources one per cycle.

Top module: `srcBank`

## Requirements
- R1: Priority value 0xFF (all ones) masks a source. No request ever carries it. A message trigger on a masked source produces no request.
- R2: A request carries global number BASE_NUM + local index, with BASE_NUM = 0x1000 by default. A reject or EOI whose number lies outside [BASE_NUM, BASE_NUM + NUM_SRC) changes no source.
- R3: A one-cycle message trigger on an unmasked source, sampled at clock edge k, shows `reqValid` high after edge k+1. The request carries that source's number, server and priority.
- R4: A message trigger on a masked source is remembered. A later configuration write that unmasks the source presents it exactly once. A further write presents nothing.
- R5: A rising level line on an unmasked level source presents it once. Holding the line high produces no further request.
- R6: A reject of a level source clears its sent state. The next resend presents it again while its line is still high.
- R7: An EOI of a level source clears its sent state, and the next resend re-presents it. An EOI of a message source has no effect: a pending reject survives it and is still replayed on resend.
- R8: A reject of a message source marks it. The next resend presents it once and clears the mark, so a second resend presents nothing.
- R9: A configuration write to a level source whose line is high and which is not sent presents it when the write unmasks it.
- R10: Reset masks every source and clears all remembered state, and `reqValid` is low during and after reset until a new event. Each source keeps its level or message type.
- R11: When several sources wait at once, they are presented in ascending index order on consecutive cycles. A resend visits index k on the k-th cycle of its walk.
- R12: A level source whose line has dropped is not presented by a resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| trigIn | input | NUM_SRC | Per-source trigger: level line, or one-cycle message pulse |
| cfgValid | input | 1 | Configuration write strobe |
| cfgIdx | input | IDX_W | Local index of the source being configured |
| cfgServer | input | SRV_W | New target server |
| cfgPrio | input | PRIO_W | New priority (all ones = masked) |
| rejValid | input | 1 | Reject strobe from a presenter |
| rejNum | input | NUM_W | Global number being rejected |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiNum | input | NUM_W | Global number being completed |
| resendReq | input | 1 | Start a resend walk over all sources |
| reqValid | output | 1 | Presentation request valid this cycle |
| reqServer | output | SRV_W | Target server of the request |
| reqNum | output | NUM_W | Global source number of the request |
| reqPrio | output | PRIO_W | Priority of the request |

## Verification
The hardest states to reach from the ports are the hidden flags: a message source that is both rejected and EOI'd, and a level source that is sent while its line stays high. Neither shows on any output until a later resend or configuration write. The stimulus therefore always pairs the strobe under test with a follow-up resend, and counts the requests that result. The sweep order is observed through cycle stamps on two rejected sources two indices apart, which must come out exactly two cycles apart.

// File: rtl/srcBankPkg.sv
package srcBankPkg;
  // width of source indices carried in the strobe bundle
  localparam int STB_IDX_W = 8;

  typedef struct packed {
    logic                 cfgStb;
    logic [STB_IDX_W-1:0] cfgIdx;
    logic                 rejStb;
    logic [STB_IDX_W-1:0] rejIdx;
    logic                 eoiStb;
    logic [STB_IDX_W-1:0] eoiIdx;
    logic                 sweepStb;
    logic [STB_IDX_W-1:0] sweepIdx;
    logic                 grantStb;
    logic [STB_IDX_W-1:0] grantIdx;
  } bankStb_t;
endpackage

// File: rtl/srcBankCtrl.sv
module srcBankCtrl
  import srcBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 16,
  parameter logic [NUM_W-1:0] BASE_NUM = 'h1000,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendReq,
  input  logic [NUM_SRC-1:0] pendVec,
  output bankStb_t           stb,
  output logic               sweepActive,
  output logic [IDX_W-1:0]   sweepPtr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic [NUM_W-1:0] rejOff, eoiOff;
  logic rejIn, eoiIn;

  assign rejOff = rejNum - BASE_NUM;
  assign eoiOff = eoiNum - BASE_NUM;
  assign rejIn  = (rejNum >= BASE_NUM) && (rejOff < NUM_W'(NUM_SRC));
  assign eoiIn  = (eoiNum >= BASE_NUM) && (eoiOff < NUM_W'(NUM_SRC));

  // resend walk: one index per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepActive <= 1'b0;
      sweepPtr    <= '0;
    end else if (sweepActive) begin
      if (sweepPtr == LAST_IDX) begin
        sweepActive <= 1'b0;
        sweepPtr    <= '0;
      end else begin
        sweepPtr <= sweepPtr + 1'b1;
      end
    end else if (resendReq) begin
      sweepActive <= 1'b1;
      sweepPtr    <= '0;
    end
  end

  // strobe decode and lowest-index grant
  always_comb begin
    stb          = '0;
    stb.cfgStb   = cfgValid && (int'(cfgIdx) < NUM_SRC);
    stb.cfgIdx   = STB_IDX_W'(cfgIdx);
    stb.rejStb   = rejValid && rejIn;
    stb.rejIdx   = rejOff[STB_IDX_W-1:0];
    stb.eoiStb   = eoiValid && eoiIn;
    stb.eoiIdx   = eoiOff[STB_IDX_W-1:0];
    stb.sweepStb = sweepActive;
    stb.sweepIdx = STB_IDX_W'(sweepPtr);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        stb.grantStb = 1'b1;
        stb.grantIdx = STB_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/srcBankData.sv
module srcBankData
  import srcBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 4,
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 16,
  parameter logic [NUM_W-1:0]   BASE_NUM   = 'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  bankStb_t           stb,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] maskPendVec,
  output logic [NUM_SRC-1:0] maskedVec,
  output logic               reqValid,
  output logic [SRV_W-1:0]   reqServer,
  output logic [NUM_W-1:0]   reqNum,
  output logic [PRIO_W-1:0]  reqPrio
);
  localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

  logic [SRV_W-1:0]  srvArr  [NUM_SRC];
  logic [PRIO_W-1:0] prioArr [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SRV_W-1:0]  srvR;
    logic [PRIO_W-1:0] prioR;
    logic pendR, pendSet;
    logic cfgHit, rejHit, eoiHit, sweepHit, grantHit;
    logic [PRIO_W-1:0] prioNext;
    logic unmaskNext;

    assign cfgHit   = stb.cfgStb   && (stb.cfgIdx   == STB_IDX_W'(i));
    assign rejHit   = stb.rejStb   && (stb.rejIdx   == STB_IDX_W'(i));
    assign eoiHit   = stb.eoiStb   && (stb.eoiIdx   == STB_IDX_W'(i));
    assign sweepHit = stb.sweepStb && (stb.sweepIdx == STB_IDX_W'(i));
    assign grantHit = stb.grantStb && (stb.grantIdx == STB_IDX_W'(i));
    assign prioNext   = cfgHit ? cfgPrio : prioR;
    assign unmaskNext = (prioNext != MASK_PRIO);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srvR  <= '0;
        prioR <= MASK_PRIO;
      end else if (cfgHit) begin
        srvR  <= cfgServer;
        prioR <= cfgPrio;
      end
    end

    if (LEVEL_MASK[i]) begin : g_level
      logic assertR, sentR, sentKept, lineRise, checkOk;
      assign lineRise = trigIn[i] & ~assertR;
      assign sentKept = sentR & ~(rejHit | eoiHit);
      assign checkOk  = (lineRise | cfgHit | sweepHit) & unmaskNext
                        & trigIn[i] & ~sentKept;
      assign pendSet  = checkOk;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          assertR <= 1'b0;
          sentR   <= 1'b0;
        end else begin
          assertR <= trigIn[i];
          sentR   <= sentKept | checkOk;
        end
      end
      assign maskPendVec[i] = 1'b0;
    end else begin : g_msg
      logic rejR, heldR;
      logic replay, resent;
      assign replay  = heldR & unmaskNext;
      assign resent  = sweepHit & rejR & unmaskNext;
      assign pendSet = (trigIn[i] & unmaskNext) | replay | resent;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rejR  <= 1'b0;
          heldR <= 1'b0;
        end else begin
          rejR  <= (rejR & ~sweepHit) | rejHit;
          heldR <= (heldR | trigIn[i]) & ~unmaskNext;
        end
      end
      assign maskPendVec[i] = heldR;
    end

    // waiting request; a masking write withdraws it
    always_ff @(posedge clk) begin
      if (!rstN) pendR <= 1'b0;
      else       pendR <= (pendR & ~grantHit & ~(cfgHit & ~unmaskNext)) | pendSet;
    end

    assign pendVec[i]   = pendR;
    assign maskedVec[i] = (prioR == MASK_PRIO);
    assign srvArr[i]    = srvR;
    assign prioArr[i]   = prioR;
  end

  logic [IDX_W-1:0] gIdx;
  assign gIdx = stb.grantIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqServer <= '0;
      reqNum    <= '0;
      reqPrio   <= '0;
    end else begin
      reqValid <= stb.grantStb;
      if (stb.grantStb) begin
        reqServer <= srvArr[gIdx];
        reqPrio   <= prioArr[gIdx];
        reqNum    <= BASE_NUM + NUM_W'(gIdx);
      end
    end
  end
endmodule

// File: rtl/srcBank.sv
module srcBank
  import srcBankPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 4,
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 16,
  parameter logic [NUM_W-1:0]   BASE_NUM   = 'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               cfgValid,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendReq,
  output logic               reqValid,
  output logic [SRV_W-1:0]   reqServer,
  output logic [NUM_W-1:0]   reqNum,
  output logic [PRIO_W-1:0]  reqPrio
);
  bankStb_t           stb;
  logic [NUM_SRC-1:0] pendVec, maskPendVec, maskedVec;
  logic               sweepActive;
  logic [IDX_W-1:0]   sweepPtr;

  srcBankCtrl #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIdx(cfgIdx),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .pendVec(pendVec), .stb(stb),
    .sweepActive(sweepActive), .sweepPtr(sweepPtr)
  );

  srcBankData #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W),
                .BASE_NUM(BASE_NUM), .LEVEL_MASK(LEVEL_MASK)) u_data (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgServer(cfgServer), .cfgPrio(cfgPrio),
    .stb(stb), .pendVec(pendVec), .maskPendVec(maskPendVec), .maskedVec(maskedVec),
    .reqValid(reqValid), .reqServer(reqServer), .reqNum(reqNum), .reqPrio(reqPrio)
  );
endmodule

// File: rtl/srcBankChk.sv
module srcBankChk #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 16,
  parameter logic [NUM_W-1:0] BASE_NUM = 'h1000,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [NUM_W-1:0]   reqNum,
  input logic [PRIO_W-1:0]  reqPrio,
  input logic [NUM_SRC-1:0] maskPendVec,
  input logic [NUM_SRC-1:0] maskedVec,
  input logic               sweepActive,
  input logic [IDX_W-1:0]   sweepPtr
);
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqPrio != {PRIO_W{1'b1}})); // R1
  AST_NUM_IN_BANK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((reqNum >= BASE_NUM) && ((reqNum - BASE_NUM) < NUM_W'(NUM_SRC)))); // R2
  AST_HELD_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ((maskPendVec & ~maskedVec) == '0)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !reqValid); // R10
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (sweepActive && $past(sweepActive)) |-> (sweepPtr == IDX_W'($past(sweepPtr) + 1'b1))); // R11
endmodule

bind srcBank srcBankChk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W),
                          .BASE_NUM(BASE_NUM)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNum(reqNum), .reqPrio(reqPrio),
  .maskPendVec(maskPendVec), .maskedVec(maskedVec),
  .sweepActive(sweepActive), .sweepPtr(sweepPtr)
);

// File: tb/sim_srcBank.sv
`timescale 1ns/1ps
module sim_srcBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] lvl = '0, msg = '0;
  logic [7:0] trigIn;
  logic cfgValid = 0, rejValid = 0, eoiValid = 0, resendReq = 0;
  logic [2:0] cfgIdx = '0;
  logic [3:0] cfgServer = '0;
  logic [7:0] cfgPrio = '0;
  logic [15:0] rejNum = '0, eoiNum = '0;
  logic reqValid;
  logic [3:0] reqServer;
  logic [15:0] reqNum;
  logic [7:0] reqPrio;

  assign trigIn = lvl | msg;
  always #2.5 clk = ~clk;

  srcBank #(.NUM_SRC(8), .LEVEL_MASK(8'hF0)) u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgValid(cfgValid), .cfgIdx(cfgIdx),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio), .rejValid(rejValid), .rejNum(rejNum),
    .eoiValid(eoiValid), .eoiNum(eoiNum), .resendReq(resendReq),
    .reqValid(reqValid), .reqServer(reqServer), .reqNum(reqNum), .reqPrio(reqPrio)
  );

  int testCnt = 0, failCnt = 0, cyc = 0, logCnt = 0;
  logic [15:0] logNum [64];
  logic [3:0]  logSrv [64];
  logic [7:0]  logPrio[64];
  int          logCyc [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rstN && reqValid && logCnt < 64) begin
      logNum[logCnt] = reqNum; logSrv[logCnt] = reqServer;
      logPrio[logCnt] = reqPrio; logCyc[logCnt] = cyc;
      logCnt = logCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (14) @(negedge clk); endtask
  task automatic clearLog(); logCnt = 0; endtask

  task automatic cfgWr(input logic [2:0] idx, input logic [3:0] srv, input logic [7:0] pr);
    cfgValid = 1; cfgIdx = idx; cfgServer = srv; cfgPrio = pr;
    @(negedge clk); cfgValid = 0;
  endtask
  task automatic sendRej(input logic [15:0] n);
    rejValid = 1; rejNum = n; @(negedge clk); rejValid = 0;
  endtask
  task automatic sendEoi(input logic [15:0] n);
    eoiValid = 1; eoiNum = n; @(negedge clk); eoiValid = 0;
  endtask
  task automatic doResend();
    resendReq = 1; @(negedge clk); resendReq = 0;
  endtask
  task automatic pulse(input logic [7:0] m);
    msg = m; @(negedge clk); msg = '0;
  endtask
  task automatic chkEntry(input string req, input int k, input logic [15:0] n,
                          input logic [3:0] s, input logic [7:0] p);
    chk(req, 32'(logNum[k]), 32'(n));
    chk(req, 32'(logSrv[k]), 32'(s));
    chk(req, 32'(logPrio[k]), 32'(p));
  endtask

  initial begin
    #(200000 * 5);
    testCnt++; failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 reqValid low in reset", 32'(reqValid), 0);
    rstN = 1;
    @(negedge clk);
    // R10: remembered masked trigger is wiped by reset
    pulse(8'h02);
    rstN = 0; repeat (3) @(negedge clk); rstN = 1; @(negedge clk);
    clearLog();
    cfgWr(3'd1, 4'd2, 8'd6);
    settle();
    chk("R10 reset clears held trigger", 32'(logCnt), 0);

    // R1: masked message trigger is silent
    clearLog(); pulse(8'h01); settle();
    chk("R1 masked trigger", 32'(logCnt), 0);

    // R4: replay on unmask, exactly once
    cfgWr(3'd0, 4'd5, 8'd9); settle();
    chk("R4 replay count", 32'(logCnt), 1);
    chkEntry("R4 replay fields", 0, 16'h1000, 4'd5, 8'd9);
    clearLog(); cfgWr(3'd0, 4'd5, 8'd9); settle();
    chk("R4 no second replay", 32'(logCnt), 0);

    // R3: exact latency and fields
    cfgWr(3'd2, 4'd3, 8'd4); settle(); clearLog();
    msg = 8'h04; @(negedge clk); msg = '0;
    chk("R3 not yet valid", 32'(reqValid), 0);
    @(negedge clk);
    chk("R3 valid after second edge", 32'(reqValid), 1);
    chk("R3 number", 32'(reqNum), 32'h1002);
    chk("R3 server", 32'(reqServer), 3);
    chk("R3 priority", 32'(reqPrio), 4);
    settle();
    chk("R3 single request", 32'(logCnt), 1);

    // R8: message reject and resend
    clearLog(); sendRej(16'h1002); settle();
    chk("R8 reject alone silent", 32'(logCnt), 0);
    doResend(); settle();
    chk("R8 resend replays", 32'(logCnt), 1);
    chkEntry("R8 replay fields", 0, 16'h1002, 4'd3, 8'd4);
    clearLog(); doResend(); settle();
    chk("R8 mark cleared", 32'(logCnt), 0);

    // R7: EOI on message source has no effect
    clearLog(); sendEoi(16'h1002); settle();
    chk("R7 message EOI silent", 32'(logCnt), 0);
    sendRej(16'h1002); sendEoi(16'h1002); doResend(); settle();
    chk("R7 message EOI keeps reject", 32'(logCnt), 1);

    // R2: out-of-range rejects are ignored
    clearLog();
    sendRej(16'h1008); sendRej(16'h0002); sendRej(16'h0FFF);
    doResend(); settle();
    chk("R2 out-of-range reject ignored", 32'(logCnt), 0);

    // R5: level rising edge presents once
    clearLog(); cfgWr(3'd5, 4'd1, 8'd3); settle();
    chk("R5 low line silent", 32'(logCnt), 0);
    lvl[5] = 1'b1; repeat (12) @(negedge clk);
    chk("R5 one request while high", 32'(logCnt), 1);
    chkEntry("R5 fields", 0, 16'h1005, 4'd1, 8'd3);

    // R7: level EOI then resend
    clearLog(); sendEoi(16'h1005); settle();
    chk("R7 level EOI alone silent", 32'(logCnt), 0);
    doResend(); settle();
    chk("R7 level resend after EOI", 32'(logCnt), 1);
    if (logCnt > 0) chk("R7 level number", 32'(logNum[0]), 32'h1005);
    clearLog(); doResend(); settle();
    chk("R7 sent again blocks resend", 32'(logCnt), 0);

    // R6: level reject then resend
    clearLog(); sendRej(16'h1005); settle();
    chk("R6 reject alone silent", 32'(logCnt), 0);
    doResend(); settle();
    chk("R6 resend after reject", 32'(logCnt), 1);

    // R12: dropped line not re-presented
    clearLog(); lvl[5] = 1'b0; @(negedge clk);
    sendEoi(16'h1005); doResend(); settle();
    chk("R12 dropped line silent", 32'(logCnt), 0);

    // R9: unmasking write on asserted level source
    clearLog(); lvl[6] = 1'b1; settle();
    chk("R9 masked level silent", 32'(logCnt), 0);
    cfgWr(3'd6, 4'd4, 8'd2); settle();
    chk("R9 unmask presents", 32'(logCnt), 1);
    chkEntry("R9 fields", 0, 16'h1006, 4'd4, 8'd2);

    // R11: ascending order, consecutive cycles
    cfgWr(3'd1, 4'd7, 8'd1); settle(); clearLog();
    pulse(8'h07); settle();
    chk("R11 three requests", 32'(logCnt), 3);
    chk("R11 first", 32'(logNum[0]), 32'h1000);
    chk("R11 second", 32'(logNum[1]), 32'h1001);
    chk("R11 third", 32'(logNum[2]), 32'h1002);
    chk("R11 back to back a", 32'(logCyc[1] - logCyc[0]), 1);
    chk("R11 back to back b", 32'(logCyc[2] - logCyc[1]), 1);

    // R11: sweep visits one index per cycle
    clearLog(); sendRej(16'h1002); sendRej(16'h1000); doResend(); settle();
    chk("R11 sweep count", 32'(logCnt), 2);
    chk("R11 sweep first", 32'(logNum[0]), 32'h1000);
    chk("R11 sweep second", 32'(logNum[1]), 32'h1002);
    chk("R11 sweep spacing", 32'(logCyc[1] - logCyc[0]), 2);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule